// File: doc/BRIEF.md
# Four-Level Preemptive Interrupt Controller

This block picks among seven interrupt request flags for an 8-bit microcontroller core and tells the core which handler to enter. Three byte-wide registers control it. The enable register holds a global gate and one gate per source. The priority-low register and the priority-high register each hold one bit per source, and the two bits of a source together give it one of four levels. The controller keeps one in-service bit per level. A request can be granted only when its level is above every level now in service. When a grant is made, the controller raises a vector strobe for one clock, together with the handler address.

The core sends a return pulse when a handler finishes. That pulse clears the highest in-service level, so the service that was interrupted carries on and waiting requests are judged again. For sources whose flag clears itself on entry, the controller also sends a one-clock hardware-clear pulse back to that flag. Requests enter as plain synchronous flags. Register access uses a write strobe and a two-bit address, and readback is combinational.

Top module: `irq4_ctrl`

## Requirements
- R1: After reset, all three registers read 00H and no vector strobe or clear pulse is active.
- R2: Address 0 selects the enable register, address 1 the priority-low register, address 2 the priority-high register, and address 3 reads 00H. A write takes effect at the clock edge. Bit 7 of both priority registers always reads 0, while all 8 bits of the enable register read back.
- R3: Enable bit 7 is a global gate. When it is 0, no request is granted. When it is 1, bits 0..6 gate sources 0..6 one by one.
- R4: Source index s (0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2, 6 counter array) has level {prio_high[s], prio_low[s]}, with 3 as the highest. Among the eligible requests, the one with the highest level wins.
- R5: Requests that tie on level are resolved by the fixed order 0, 1, 2, 3, 6, 5's predecessor 4, then 5. In words: external 0, timer 0, external 1, timer 1, counter array, serial, timer 2.
- R6: The vector equals 8*s+3: 03H, 0BH, 13H, 1BH, 23H, 2BH and 33H for sources 0..6.
- R7: A request that is eligible in cycle n gives vec_stb_o high for exactly cycle n+1, with vec_o valid in that cycle. The in-service bit of its level is set at the same edge.
- R8: A request whose level is equal to or lower than the highest level in service is held off.
- R9: A request of higher level than every level in service is granted at once, which nests service up to four levels deep.
- R10: A return pulse clears the highest in-service bit. Requests are judged against the state before the clock edge, so a held-off request can win in the cycle after the pop.
- R11: hw_clr_o[s] pulses together with the strobe. Timer 0 and timer 1 always pulse. External 0 and external 1 pulse only when ext_edge_i[0] or ext_edge_i[1] respectively is 1. Serial, timer 2 and counter array never pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for write and read |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i |
| req_i | input | 7 | Request flags, indexed by source |
| ext_edge_i | input | 2 | Edge-triggered mode of external 0 / external 1 |
| reti_i | input | 1 | Return-from-interrupt pulse |
| vec_stb_o | output | 1 | One-clock grant strobe |
| vec_o | output | 8 | Handler address of the granted source |
| hw_clr_o | output | 7 | One-clock clear pulse to self-clearing flags |

## Verification
The bench targets several corner cases, and each has a typical failure.
- Level ties: sources 4 and 6 break ties in an order that is not their index order. A scan that follows index order returns 23H where 33H is due.
- Equal-level re-requests: a level-held request that stays high after its grant must not be granted again. A design that compares with greater-or-equal would strobe on every cycle.
- Return followed by a waiting request: a return and a waiting request in the same cycle must not grant until the next cycle. A design that pops before comparing would grant one cycle early.
- Deep nesting: a three-deep nest must unwind one level per return.
- Clear pulses: the external sources must pulse only in edge mode.

Randomised register settings, requests and returns check every cycle against a model of the requirements.

// File: rtl/irq4_pkg.sv
package irq4_pkg;
  localparam int NUM_SRC = 7;
  localparam int NUM_LVL = 4;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;

  typedef logic [SRC_W-1:0] src_t;
  typedef logic [LVL_W-1:0] lvl_t;

  // tie-break scan: slot k -> source index
  function automatic src_t poll_src(input int k);
    case (k)
      4:       return src_t'(6);
      5:       return src_t'(4);
      6:       return src_t'(5);
      default: return src_t'(k);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] vec_of(input src_t s);
    return {2'b00, s, 3'b011};
  endfunction
endpackage

// File: rtl/irq4_regs.sv
module irq4_regs
  import irq4_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    glb_en_o,
  output logic [NUM_SRC-1:0]      src_en_o,
  output logic [NUM_SRC-1:0]      prio_lo_o,
  output logic [NUM_SRC-1:0]      prio_hi_o
);
  logic [DATA_W-1:0]  en_q;
  logic [NUM_SRC-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        2'd0:    en_q <= wr_data_i;
        2'd1:    lo_q <= wr_data_i[NUM_SRC-1:0];
        2'd2:    hi_q <= wr_data_i[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      2'd0:    rd_data_o = en_q;
      2'd1:    rd_data_o = DATA_W'(lo_q);
      2'd2:    rd_data_o = DATA_W'(hi_q);
      default: rd_data_o = '0;
    endcase
  end

  assign glb_en_o  = en_q[DATA_W-1];
  assign src_en_o  = en_q[NUM_SRC-1:0];
  assign prio_lo_o = lo_q;
  assign prio_hi_o = hi_q;
endmodule

// File: rtl/irq4_arbiter.sv
module irq4_arbiter
  import irq4_pkg::*;
(
  input  logic [NUM_SRC-1:0] elig_i,
  input  logic [NUM_SRC-1:0] prio_lo_i,
  input  logic [NUM_SRC-1:0] prio_hi_i,
  output logic               found_o,
  output src_t               src_o,
  output lvl_t               lvl_o
);
  lvl_t lvl [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
    assign lvl[i] = {prio_hi_i[i], prio_lo_i[i]};
  end

  // strict '>' keeps the earlier slot on a tie
  always_comb begin
    found_o = 1'b0;
    src_o   = '0;
    lvl_o   = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (elig_i[poll_src(k)] && (!found_o || lvl[poll_src(k)] > lvl_o)) begin
        found_o = 1'b1;
        src_o   = poll_src(k);
        lvl_o   = lvl[poll_src(k)];
      end
    end
  end
endmodule

// File: rtl/irq4_isr_stack.sv
module irq4_isr_stack
  import irq4_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  lvl_t               push_lvl_i,
  input  logic               pop_i,
  output logic               busy_o,
  output lvl_t               top_lvl_o,
  output logic [NUM_LVL-1:0] isr_o
);
  logic [NUM_LVL-1:0] isr_q, clr_mask, set_mask;

  always_comb begin
    top_lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (isr_q[l]) top_lvl_o = lvl_t'(l);
  end

  assign busy_o   = |isr_q;
  assign clr_mask = (pop_i && busy_o) ? (NUM_LVL'(1) << top_lvl_o) : '0;
  assign set_mask = push_i ? (NUM_LVL'(1) << push_lvl_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~clr_mask) | set_mask;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/irq4_ctrl.sv
module irq4_ctrl
  import irq4_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic [NUM_SRC-1:0]    req_i,
  input  logic [1:0]            ext_edge_i,
  input  logic                  reti_i,
  output logic                  vec_stb_o,
  output logic [DATA_W-1:0]     vec_o,
  output logic [NUM_SRC-1:0]    hw_clr_o
);
  logic               ea_w, found, busy, grant;
  logic [NUM_SRC-1:0] src_en, prio_lo, prio_hi, elig, self_clr;
  src_t               win_src;
  lvl_t               win_lvl, top_lvl;
  logic [NUM_LVL-1:0] isr_w;

  irq4_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wr_data_i, .rd_data_o,
    .glb_en_o(ea_w), .src_en_o(src_en), .prio_lo_o(prio_lo), .prio_hi_o(prio_hi)
  );

  assign elig = ea_w ? (req_i & src_en) : '0;

  irq4_arbiter u_arb (
    .elig_i(elig), .prio_lo_i(prio_lo), .prio_hi_i(prio_hi),
    .found_o(found), .src_o(win_src), .lvl_o(win_lvl)
  );

  assign grant = found && (!busy || win_lvl > top_lvl);

  irq4_isr_stack u_isr (
    .clk_i, .rst_ni, .push_i(grant), .push_lvl_i(win_lvl), .pop_i(reti_i),
    .busy_o(busy), .top_lvl_o(top_lvl), .isr_o(isr_w)
  );

  // flags cleared on entry: timers always, externals in edge mode
  assign self_clr = {3'b000, 1'b1, ext_edge_i[1], 1'b1, ext_edge_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_stb_o <= 1'b0;
      vec_o     <= '0;
      hw_clr_o  <= '0;
    end else begin
      vec_stb_o <= grant;
      hw_clr_o  <= grant ? ((NUM_SRC'(1) << win_src) & self_clr) : '0;
      if (grant) vec_o <= vec_of(win_src);
    end
  end
endmodule

// File: rtl/irq4_ctrl_sva.sv
module irq4_ctrl_sva
  import irq4_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ea_w,
  input logic               reti_i,
  input logic               vec_stb_o,
  input logic [DATA_W-1:0]  vec_o,
  input logic [NUM_SRC-1:0] hw_clr_o,
  input logic [NUM_LVL-1:0] isr_w
);
  a_r3_grant_needs_global: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_stb_o |-> $past(ea_w));

  a_r11_clr_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_clr_o) |-> (vec_stb_o && $onehot(hw_clr_o)));

  a_r11_timer0_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_clr_o[1] |-> vec_o == 8'h0B);

  a_r9_push_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_stb_o |-> ($onehot(isr_w & ~$past(isr_w)) && ((isr_w & ~$past(isr_w)) > $past(isr_w))));

  a_r10_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(reti_i) && $past(isr_w) != 0 && !vec_stb_o) |->
      $countones(isr_w) + 1 == $countones($past(isr_w)));

  a_r7_isr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_stb_o && !$past(reti_i)) |-> $stable(isr_w));
endmodule

bind irq4_ctrl irq4_ctrl_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .ea_w(ea_w), .reti_i(reti_i),
  .vec_stb_o(vec_stb_o), .vec_o(vec_o), .hw_clr_o(hw_clr_o), .isr_w(isr_w)
);

// File: tb/irq4_ctrl_bench.sv
module irq4_ctrl_bench;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wr_data_i = '0, rd_data_o;
  logic [6:0] req_i = '0, hw_clr_o;
  logic [1:0] ext_edge_i = '0;
  logic       reti_i = 1'b0, vec_stb_o;
  logic [7:0] vec_o;

  int nchk = 0, nfail = 0;
  logic [7:0] m_en = '0;
  logic [6:0] m_lo = '0, m_hi = '0;
  logic [3:0] m_isr = '0;

  localparam int POLL [7] = '{0, 1, 2, 3, 6, 4, 5};
  localparam logic [7:0] VEC [7] = '{8'h03, 8'h0B, 8'h13, 8'h1B, 8'h23, 8'h2B, 8'h33};

  always #2.5 clk = ~clk;

  irq4_ctrl u_irq4_ctrl (.clk_i(clk), .*);

  function automatic int pick(output int lv);
    lv = 0;
    if (!m_en[7]) return -1;
    for (int l = 3; l >= 0; l--)
      for (int k = 0; k < 7; k++)
        if (m_en[POLL[k]] && req_i[POLL[k]] && int'({m_hi[POLL[k]], m_lo[POLL[k]]}) == l) begin
          lv = l;
          return POLL[k];
        end
    return -1;
  endfunction

  function automatic int top_of(input logic [3:0] v);
    int t = -1;
    for (int l = 0; l < 4; l++) if (v[l]) t = l;
    return t;
  endfunction

  task automatic report();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic check_rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
    addr_i = a;
    #1;
    nchk++;
    if (rd_data_o !== exp) begin
      nfail++;
      $display("FAIL %s: read addr %0d got %h expected %h", tag, a, rd_data_o, exp);
    end
  endtask

  // one clock; inputs already driven; checks outputs after the edge
  task automatic step(input string tag);
    int g, glv, t;
    logic exp_stb;
    logic [7:0] exp_vec;
    logic [6:0] exp_clr;
    g = pick(glv);
    t = top_of(m_isr);
    exp_stb = (g >= 0) && (glv > t);
    exp_vec = exp_stb ? VEC[g] : 8'h00;
    exp_clr = '0;
    if (exp_stb) begin
      if (g == 1 || g == 3) exp_clr[g] = 1'b1;
      if (g == 0) exp_clr[0] = ext_edge_i[0];
      if (g == 2) exp_clr[2] = ext_edge_i[1];
    end
    @(posedge clk);
    #1;
    nchk++;
    if (vec_stb_o !== exp_stb || (exp_stb && vec_o !== exp_vec) || hw_clr_o !== exp_clr) begin
      nfail++;
      $display("FAIL %s: stb/vec/clr %b/%h/%b expected %b/%h/%b",
               tag, vec_stb_o, vec_o, hw_clr_o, exp_stb, exp_vec, exp_clr);
    end
    if (reti_i && t >= 0) m_isr[t] = 1'b0;
    if (exp_stb) m_isr[glv] = 1'b1;
    if (wr_en_i) case (addr_i)
      2'd0: m_en = wr_data_i;
      2'd1: m_lo = wr_data_i[6:0];
      2'd2: m_hi = wr_data_i[6:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    step("R2");
    wr_en_i = 1'b0;
  endtask

  task automatic ret(input string tag);
    reti_i = 1'b1;
    step(tag);
    reti_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run hung, got timeout expected finish");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    nchk++;
    if (vec_stb_o !== 1'b0 || hw_clr_o !== '0) begin
      nfail++;
      $display("FAIL R1: stb/clr %b/%b expected 0/0", vec_stb_o, hw_clr_o);
    end
    for (int a = 0; a < 4; a++) check_rd("R1", 2'(a), 8'h00);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    // R2 register access
    wr(2'd2, 8'hFF); check_rd("R2", 2'd2, 8'h7F);
    wr(2'd1, 8'hAA); check_rd("R2", 2'd1, 8'h2A);
    wr(2'd0, 8'h7F); check_rd("R2", 2'd0, 8'h7F);
    check_rd("R2", 2'd3, 8'h00);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R3 global gate off, then individual gates off
    req_i = 7'h7F;
    repeat (3) step("R3");
    wr(2'd0, 8'h80);
    repeat (2) step("R3");
    req_i = '0;

    // R5/R6 tie order: counter array ahead of serial and timer 2
    wr(2'd0, 8'hFF);
    req_i = 7'b111_0000; step("R5");
    req_i = '0; ret("R6");
    req_i = 7'b011_0000; step("R6");
    req_i = '0; ret("R5");
    req_i = 7'b100_0000; step("R6");
    req_i = '0; ret("R6");

    // R4 highest level wins over poll order
    wr(2'd1, 8'h20); wr(2'd2, 8'h20);
    req_i = 7'h7F; step("R4");
    req_i = '0; ret("R4");

    // R8/R9/R10 nesting: ext0 L1, serial L2, timer2 L3
    wr(2'd1, 8'h21); wr(2'd2, 8'h30);
    req_i = 7'b000_0001; step("R7");
    step("R8");
    req_i = 7'b001_0001; step("R9");
    req_i = 7'b011_0001; step("R9");
    step("R8");
    req_i = 7'b000_0001;
    ret("R10"); ret("R10");
    ret("R10");
    step("R10");
    req_i = '0; ret("R10");

    // R11 clear pulses
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    ext_edge_i = 2'b01;
    req_i = 7'b000_0001; step("R11"); req_i = '0; ret("R11");
    req_i = 7'b000_0100; step("R11"); req_i = '0; ret("R11");
    ext_edge_i = 2'b10;
    req_i = 7'b000_0100; step("R11"); req_i = '0; ret("R11");
    req_i = 7'b000_1000; step("R11"); req_i = '0; ret("R11");
    req_i = 7'b000_0010; step("R11"); req_i = '0; ret("R11");
    req_i = 7'b001_0000; step("R11"); req_i = '0; ret("R11");

    // random mix
    void'($urandom(32'd12345));
    for (int i = 0; i < 4000; i++) begin
      req_i      = 7'($urandom) & 7'($urandom);
      reti_i     = ($urandom % 5) == 0;
      ext_edge_i = 2'($urandom);
      wr_en_i    = ($urandom % 23) == 0;
      addr_i     = 2'($urandom);
      wr_data_i  = 8'($urandom) | (($urandom % 4 != 0) ? 8'h80 : 8'h00);
      step("R9");
    end
    wr_en_i = 1'b0; reti_i = 1'b0; req_i = '0;
    report();
  end
endmodule